// File: doc/BRIEF.md
# Frame Byte-Code Decompressor

This block rebuilds the bytes of one configuration frame from a serial, MSB-first bit stream that was packed with a small prefix code of four cases. A single 0 bit stands for a zero byte. `100` followed by three bits stands for a byte that has only one bit set. `101` followed by three bits points at one of eight stored bytes. `11` followed by eight bits carries the byte as a literal. Software fills the eight-entry table of stored bytes through a write port before a frame starts.

The upstream logic presents one bit per cycle at most, on a valid/data pair. The block emits one byte, with a one-cycle strobe, for each code that completes. It knows how many output bytes the frame holds from the length input, which it captures on the first bit of the frame. After the last byte it throws away the filler bits up to the next multiple of eight input bits, counted from the start of the frame. It then pulses a done strobe and waits for the next frame.

Top module: `frame_byte_decomp`

## Requirements
- R1: A code made of the single bit 0 produces the output byte 0x00.
- R2: The bits 1,0,0 followed by a 3-bit position p (MSB first) produce a byte with only bit p set, where bit 0 is the LSB. For example, 100101 gives 0x20.
- R3: The bits 1,0,1 followed by a 3-bit index i (MSB first) produce the stored table entry i.
- R4: The bits 1,1 followed by eight bits produce those eight bits as the byte, with the first received bit as bit 7.
- R5: One input bit is taken per cycle in which `bit_vld` is high, and nothing changes while it is low. `byte_vld` is high for exactly one cycle: the cycle after the clock edge that accepts the last bit of a code. `byte_out` is valid in that cycle.
- R6: After `frame_len` bytes have been produced, `frame_done` is high for one cycle once the number of input bits accepted since the frame began is a multiple of 8. When the last code already ends on such a boundary, `frame_done` rises in the same cycle as the last `byte_vld`.
- R7: Filler bits between the last byte and the boundary produce no byte, whatever their values.
- R8: A table write (`tbl_we`) in a cycle where a frame is in progress has no effect. A write while idle, including the cycle of the frame's first bit, stores the entry.
- R9: Reset clears `byte_vld` and `frame_done`, returns the block to idle, and sets every table entry to 0x00.
- R10: `frame_len` is sampled only on the first bit of a frame, so changing it later in the frame does not alter that frame's byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | An input bit is offered this cycle |
| bit_in | input | 1 | Input bit of the compressed stream |
| tbl_we | input | 1 | Write strobe for the byte table |
| tbl_idx | input | 3 | Table entry to write |
| tbl_data | input | 8 | Byte to store |
| frame_len | input | LEN_W | Number of output bytes in the frame |
| byte_vld | output | 1 | Output byte strobe |
| byte_out | output | 8 | Reconstructed byte |
| frame_done | output | 1 | Frame complete strobe |

## Verification
The prefix decoder keeps its state across codes. If that state goes wrong, the next output byte comes out with the wrong value or in the wrong cycle, and every later byte of the frame is shifted as well. The bench therefore compares `byte_vld` and `byte_out` on every cycle, not only the values. The position counter and the byte counter show up only at the end of the frame, as a `frame_done` strobe that comes too early or too late, or as stray bytes decoded from filler bits. Filler bits of all ones make those stray bytes visible at once. A table write that leaks during a frame shows up only on a later reference to that entry, so the bench reads the entry back in the frame that follows.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
    localparam int BYTE_W   = 8;
    localparam int TBL_N    = 8;
    localparam int TBL_IW   = $clog2(TBL_N);
    localparam int CNT_W    = 4;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_ONE,
        ST_ONEZERO,
        ST_ARG,
        ST_PAD
    } st_e;

    typedef enum logic [1:0] {
        K_HOT,
        K_TBL,
        K_LIT
    } kind_e;
endpackage

// File: rtl/fbd_dict.sv
module fbd_dict #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IW-1:0]          widx,
    input  logic [WIDTH-1:0]       wdata,
    input  logic [IW-1:0]          ridx,
    output logic [WIDTH-1:0]       rdata,
    output logic [DEPTH*WIDTH-1:0] flat
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[ridx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[g*WIDTH +: WIDTH] = mem_q[g];
    end
endmodule

// File: rtl/fbd_expand.sv
module fbd_expand
    import fbd_pkg::*;
(
    input  kind_e              kind,
    input  logic [BYTE_W-1:0]  code,
    input  logic [BYTE_W-1:0]  tbl_byte,
    output logic [BYTE_W-1:0]  value
);
    logic [BYTE_W-1:0] hot;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_hot
        assign hot[g] = (code[TBL_IW-1:0] == TBL_IW'(g));
    end

    always_comb begin
        case (kind)
            K_HOT:   value = hot;
            K_TBL:   value = tbl_byte;
            default: value = code;
        endcase
    end
endmodule

// File: rtl/frame_byte_decomp.sv
module frame_byte_decomp
    import fbd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_vld,
    input  logic               bit_in,
    input  logic               tbl_we,
    input  logic [2:0]         tbl_idx,
    input  logic [7:0]         tbl_data,
    input  logic [LEN_W-1:0]   frame_len,
    output logic               byte_vld,
    output logic [7:0]         byte_out,
    output logic               frame_done
);
    localparam int POS_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              act;
        st_e               st;
        kind_e             kind;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] arg;
        logic [POS_W-1:0]  pos;
        logic [LEN_W-1:0]  left;
        logic              ovld;
        logic [BYTE_W-1:0] obyte;
        logic              done;
    } regs_t;

    regs_t d, q;

    logic [BYTE_W-1:0]       shifted;
    logic [BYTE_W-1:0]       tbl_rd;
    logic [BYTE_W-1:0]       expanded;
    logic [TBL_N*BYTE_W-1:0] dict_flat;
    st_e                     st_now;
    logic [LEN_W-1:0]        left_now;
    logic [POS_W-1:0]        pos_nxt;
    logic                    emit;

    assign shifted = {q.arg[BYTE_W-2:0], bit_in};

    // writes land only while no frame is in flight
    fbd_dict #(.DEPTH(TBL_N), .WIDTH(BYTE_W)) u_dict (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we & ~q.act),
        .widx  (tbl_idx),
        .wdata (tbl_data),
        .ridx  (shifted[TBL_IW-1:0]),
        .rdata (tbl_rd),
        .flat  (dict_flat)
    );

    fbd_expand u_expand (
        .kind     (q.kind),
        .code     (shifted),
        .tbl_byte (tbl_rd),
        .value    (expanded)
    );

    always_comb begin
        d        = q;
        d.ovld   = 1'b0;
        d.done   = 1'b0;
        st_now   = q.act ? q.st : ST_HEAD;
        left_now = q.act ? q.left : frame_len;
        pos_nxt  = q.act ? q.pos + POS_W'(1) : POS_W'(1);
        emit     = 1'b0;
        if (bit_vld) begin
            d.act  = 1'b1;
            d.pos  = pos_nxt;
            d.left = left_now;
            case (st_now)
                ST_HEAD: begin
                    if (!bit_in) begin
                        emit    = 1'b1;
                        d.obyte = '0;
                    end else begin
                        d.st = ST_ONE;
                    end
                end
                ST_ONE: begin
                    if (bit_in) begin
                        d.st   = ST_ARG;
                        d.kind = K_LIT;
                        d.cnt  = CNT_W'(BYTE_W);
                    end else begin
                        d.st = ST_ONEZERO;
                    end
                end
                ST_ONEZERO: begin
                    d.st   = ST_ARG;
                    d.kind = bit_in ? K_TBL : K_HOT;
                    d.cnt  = CNT_W'(TBL_IW);
                end
                ST_ARG: begin
                    d.arg = shifted;
                    d.cnt = q.cnt - CNT_W'(1);
                    if (q.cnt == CNT_W'(1)) begin
                        emit    = 1'b1;
                        d.obyte = expanded;
                    end
                end
                default: begin
                    if (pos_nxt == '0) begin
                        d.act  = 1'b0;
                        d.done = 1'b1;
                        d.st   = ST_HEAD;
                    end
                end
            endcase
            if (emit) begin
                d.ovld = 1'b1;
                d.left = left_now - LEN_W'(1);
                d.st   = ST_HEAD;
                if (left_now == LEN_W'(1)) begin
                    if (pos_nxt == '0) begin
                        d.act  = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_PAD;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld   = q.ovld;
    assign byte_out   = q.obyte;
    assign frame_done = q.done;
endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
    parameter int FLAT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              byte_vld,
    input logic              frame_done,
    input logic              act,
    input logic              tbl_we,
    input logic [FLAT_W-1:0] dict_flat
);
    assert_quiet_without_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> (!byte_vld && !frame_done));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_table_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && tbl_we) |=> $stable(dict_flat));

    assert_frame_starts_on_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $past(bit_vld));

    assert_byte_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(bit_vld));
endmodule

bind frame_byte_decomp fbd_checker #(.FLAT_W(64)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .byte_vld   (byte_vld),
    .frame_done (frame_done),
    .act        (q.act),
    .tbl_we     (tbl_we),
    .dict_flat  (dict_flat)
);

// File: tb/frame_byte_decomp_test.sv
module frame_byte_decomp_test;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bit_vld, bit_in, tbl_we;
    logic [2:0]       tbl_idx;
    logic [7:0]       tbl_data;
    logic [LEN_W-1:0] frame_len;
    logic             byte_vld, frame_done;
    logic [7:0]       byte_out;

    always #5 clk = ~clk;

    frame_byte_decomp #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .frame_len(frame_len), .byte_vld(byte_vld), .byte_out(byte_out),
        .frame_done(frame_done)
    );

    int total = 0;
    int bad   = 0;
    logic [7:0] tmodel [8];

    bit         qb[$];
    bit         qf[$];
    logic [7:0] qv[$];
    bit         qd[$];
    string      qt[$];

    bit         pv, pd;
    logic [7:0] pb;
    string      pt;

    task automatic check(bit ok, string req, string what, int actual, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expv);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic put(bit b, bit fin, logic [7:0] v, string t);
        qb.push_back(b); qf.push_back(fin); qv.push_back(v);
        qd.push_back(1'b0); qt.push_back(t);
    endtask

    task automatic put_field(int val, int n, logic [7:0] v, string t);
        for (int k = n - 1; k >= 0; k--) put(val[k], k == 0, v, t);
    endtask

    task automatic enc_zero();
        put(1'b0, 1'b1, 8'h00, "R1");
    endtask

    task automatic enc_hot(int p);
        put(1'b1, 1'b0, 8'h00, "R2"); put(1'b0, 1'b0, 8'h00, "R2");
        put(1'b0, 1'b0, 8'h00, "R2");
        put_field(p, 3, 8'(1 << p), "R2");
    endtask

    task automatic enc_tbl(int i);
        put(1'b1, 1'b0, 8'h00, "R3"); put(1'b0, 1'b0, 8'h00, "R3");
        put(1'b1, 1'b0, 8'h00, "R3");
        put_field(i, 3, tmodel[i], "R3");
    endtask

    task automatic enc_lit(logic [7:0] b);
        put(1'b1, 1'b0, 8'h00, "R4"); put(1'b1, 1'b0, 8'h00, "R4");
        put_field(int'(b), 8, b, "R4");
    endtask

    task automatic check_prev();
        check(byte_vld == pv, pt, "byte_vld", int'(byte_vld), int'(pv));
        if (pv && byte_vld) check(byte_out == pb, pt, "byte_out", int'(byte_out), int'(pb));
        check(frame_done == pd, "R6 R10", "frame_done", int'(frame_done), int'(pd));
    endtask

    task automatic table_write(int i, logic [7:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 3'(i); tbl_data = v;
        @(negedge clk);
        tbl_we = 1'b0;
        tmodel[i] = v;
    endtask

    // drives the queued codes, adds filler bits, checks every cycle
    task automatic run_frame(int nbytes, bit pad_ones, int gap_pct,
                             int poke_at, int pidx, logic [7:0] pval);
        int n = qb.size();
        int pad = (8 - n % 8) % 8;
        for (int k = 0; k < pad; k++) put(pad_ones, 1'b0, 8'h00, "R7");
        qd[qd.size() - 1] = 1'b1;
        frame_len = LEN_W'(nbytes);
        pv = 1'b0; pd = 1'b0; pt = "R5";
        for (int i = 0; i < qb.size(); i++) begin
            while (int'($urandom_range(99)) < gap_pct) begin
                @(negedge clk); check_prev();
                bit_vld = 1'b0; tbl_we = 1'b0;
                pv = 1'b0; pd = 1'b0; pt = "R5";
            end
            @(negedge clk); check_prev();
            bit_vld = 1'b1; bit_in = qb[i];
            tbl_we = (i == poke_at); tbl_idx = 3'(pidx); tbl_data = pval;
            if (i == 1) frame_len = ~LEN_W'(nbytes);
            pv = qf[i]; pb = qv[i]; pd = qd[i]; pt = qt[i];
        end
        @(negedge clk); check_prev();
        bit_vld = 1'b0; tbl_we = 1'b0;
        pv = 1'b0; pd = 1'b0; pt = "R5";
        @(negedge clk); check_prev();
        qb.delete(); qf.delete(); qv.delete(); qd.delete(); qt.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 0, 1);
        finish_run();
    end

    initial begin
        int nb;
        int r;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) tmodel[i] = 8'h00;
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; tbl_we = 1'b0;
        tbl_idx = '0; tbl_data = '0; frame_len = LEN_W'(8);
        repeat (3) @(negedge clk);
        check(byte_vld == 1'b0, "R9", "byte_vld in reset", int'(byte_vld), 0);
        check(frame_done == 1'b0, "R9", "frame_done in reset", int'(frame_done), 0);
        rst_n = 1'b1;

        // R9: the table reads back zero after reset
        for (int i = 0; i < 8; i++) enc_tbl(i);
        run_frame(8, 1'b0, 0, -1, 0, 8'h00);

        for (int i = 0; i < 8; i++) table_write(i, 8'h37 + 8'(i * 29));

        // R1 and R6: eight zero bytes end exactly on a boundary
        for (int i = 0; i < 8; i++) enc_zero();
        run_frame(8, 1'b0, 0, -1, 0, 8'h00);

        // R2: every bit position
        for (int i = 0; i < 8; i++) enc_hot(i);
        run_frame(8, 1'b0, 20, -1, 0, 8'h00);

        // R3: every table entry
        for (int i = 7; i >= 0; i--) enc_tbl(i);
        run_frame(8, 1'b0, 0, -1, 0, 8'h00);

        // R4: literals, including ones the short codes could have carried
        enc_lit(8'hA5); enc_lit(8'h00); enc_lit(8'hFF); enc_lit(8'h01);
        enc_lit(8'h80); enc_lit(8'h5A); enc_lit(8'hC3); enc_lit(8'h7E);
        run_frame(8, 1'b0, 10, -1, 0, 8'h00);

        // R7: filler bits of all ones decode to nothing
        enc_zero(); enc_zero(); enc_zero();
        run_frame(3, 1'b1, 0, -1, 0, 8'h00);
        enc_hot(4); enc_zero();
        run_frame(2, 1'b1, 30, -1, 0, 8'h00);

        // R8: a write in the middle of a frame is dropped
        for (int i = 0; i < 8; i++) enc_zero();
        run_frame(8, 1'b0, 0, 3, 3, 8'hE1);
        for (int i = 0; i < 8; i++) enc_tbl(3);
        run_frame(8, 1'b0, 0, -1, 0, 8'h00);
        table_write(3, 8'hE1);
        for (int i = 0; i < 8; i++) enc_tbl(3);
        run_frame(8, 1'b0, 0, -1, 0, 8'h00);

        // mixed random frames with idle cycles between bits
        for (int f = 0; f < 40; f++) begin
            nb = 8 * (1 + int'($urandom_range(3)));
            for (int b = 0; b < nb; b++) begin
                r = int'($urandom_range(99));
                if (r < 25)      enc_zero();
                else if (r < 45) enc_hot(int'($urandom_range(7)));
                else if (r < 70) enc_tbl(int'($urandom_range(7)));
                else             enc_lit(8'($urandom));
            end
            run_frame(nb, f[0], int'($urandom_range(40)), -1, 0, 8'h00);
        end
        finish_run();
    end
endmodule